// File: doc/BRIEF.md
# Dual Watermark FIFO with Transfer Requests

This block holds two independent first-in first-out queues of 32-bit entries, 16 entries each. The transmit queue is filled from the processor or DMA side and drained by a serial engine. The receive queue is filled by the serial engine and drained by the processor or DMA side. Every push or pop moves exactly one whole entry, whatever the width of the bus access that caused it.

Each queue drives a level request that an interrupt controller or DMA engine can use. A 3-bit watermark code sets the threshold for each queue. The transmit request looks at free space and the receive request looks at stored data, so one code gives mirrored thresholds in the two directions. The request is computed from the current occupancy and code and then registered, so it follows the occupancy with a delay of one clock.

Misuse is tolerated. A push into a full queue or a pop from an empty one has no effect and raises a sticky flag. A flush input empties one queue in a single cycle.

Top module: `dual_wm_fifo`

## Requirements
- R1: While reset is held, both counts read 0 and both requests and all four error flags read 0.
- R2: Each accepted push stores one whole 32-bit word. Each accepted pop removes one word. Words leave in the order they arrived. The read data port always shows the oldest stored word.
- R3: The count tracks the stored entries from 0 to 16. A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged and are both accepted.
- R4: A push while the queue holds 16 entries is dropped, even if a pop happens in the same cycle. The drop sets the sticky overflow flag, which stays set until its clear input is pulsed.
- R5: A pop while the queue is empty is dropped and leaves the count at 0. The drop sets the sticky underflow flag, which stays set until its clear input is pulsed.
- R6: The transmit request is high when free space (16 minus count) meets the code's minimum. The minimums are: 000 needs 16 free, 100 needs 12 or more, 101 needs 8 or more, 110 needs 4 or more, 111 needs 1 or more.
- R7: The receive request is high when the count meets the code's minimum. The minimums are: 000 needs 1 or more, 100 needs 4 or more, 101 needs 8 or more, 110 needs 12 or more, 111 needs all 16. Both requests reflect count and code as sampled at the previous clock edge, so they rise and fall one cycle after the count changes.
- R8: Codes 001, 010 and 011 behave exactly like 000 in both directions.
- R9: A flush pulse empties its own queue in one cycle. It leaves the other queue's count and contents and all error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wm_code | input | 3 | Transmit watermark code |
| rx_wm_code | input | 3 | Receive watermark code |
| tx_push | input | 1 | Bus side writes one entry into the transmit queue |
| tx_wdata | input | 32 | Transmit write data |
| tx_pop | input | 1 | Serial engine takes one transmit entry |
| tx_rdata | output | 32 | Oldest transmit entry |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_ovf_clr | input | 1 | Clear transmit overflow flag |
| tx_udf_clr | input | 1 | Clear transmit underflow flag |
| tx_count | output | 5 | Transmit entries stored |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| tx_req | output | 1 | Transmit transfer request |
| rx_push | input | 1 | Serial engine writes one receive entry |
| rx_wdata | input | 32 | Receive write data |
| rx_pop | input | 1 | Bus side reads one receive entry |
| rx_rdata | output | 32 | Oldest receive entry |
| rx_flush | input | 1 | Empty the receive queue |
| rx_ovf_clr | input | 1 | Clear receive overflow flag |
| rx_udf_clr | input | 1 | Clear receive underflow flag |
| rx_count | output | 5 | Receive entries stored |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |
| rx_req | output | 1 | Receive transfer request |

## Verification
The request logic is swept over every occupancy from 0 to 16 and all eight codes, in both directions. This tells apart off-by-one thresholds, mirrored tables that have been swapped, and wrong handling of the three unused codes. A full fill-and-drain pass with distinct words checks ordering and pointer wrap. The overflow test pushes a marked word into a full queue, so a dropped push can be told apart from one that overwrites data. A paired push and pop, and a flush of one queue while the other holds data, separate count errors from pointer errors and show whether one direction leaks into the other. A single fall of the receive request checks the one-cycle registered latency.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

  localparam int WM_W = 3;

  // Minimum free entries that raise the transmit request.
  function automatic int tx_free_min(input logic [WM_W-1:0] code, input int depth);
    int q;
    q = depth / 4;
    if (!code[2]) return depth;
    case (code[1:0])
      2'd0:    return 3 * q;
      2'd1:    return 2 * q;
      2'd2:    return q;
      default: return 1;
    endcase
  endfunction

  // Minimum stored entries that raise the receive request.
  function automatic int rx_data_min(input logic [WM_W-1:0] code, input int depth);
    int q;
    q = depth / 4;
    if (!code[2]) return 1;
    return (int'(code[1:0]) + 1) * q;
  endfunction

endpackage

// File: rtl/dwf_fifo_core.sv
module dwf_fifo_core #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             flush_i,
  input  logic             ovf_clr_i,
  input  logic             udf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             udf_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  // Named events used by the logic and by the checks.
  logic full, empty, push_ok, pop_ok, ovf_evt, udf_evt;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i & ~full  & ~flush_i;
  assign pop_ok  = pop_i  & ~empty & ~flush_i;
  assign ovf_evt = push_i & full   & ~flush_i;
  assign udf_evt = pop_i  & empty  & ~flush_i;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      ovf_o <= (ovf_o & ~ovf_clr_i) | ovf_evt;
      udf_o <= (udf_o & ~udf_clr_i) | udf_evt;
    end
  end

  assign rdata_o = mem[rd_ptr];
  assign cnt_o   = cnt_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R3
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !full && !empty && !flush_i) |=> $stable(cnt_q));

  // R4
  full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full && !flush_i) |=> (cnt_q == $past(cnt_q)));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !flush_i) |=> ovf_o);

  // R5
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty && !flush_i) |=> (cnt_q == '0));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty && !flush_i) |=> udf_o);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0));

endmodule

// File: rtl/dwf_req_gen.sv
module dwf_req_gen
  import dwf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [WM_W-1:0]  code_i,
  output logic             req_o
);

  logic cond;

  generate
    if (IS_TX) begin : g_tx
      always_comb cond = (DEPTH - int'(cnt_i)) >= tx_free_min(code_i, DEPTH);
    end else begin : g_rx
      always_comb cond = int'(cnt_i) >= rx_data_min(code_i, DEPTH);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= cond;
  end

  generate
    if (IS_TX) begin : g_tx_chk
      // R6
      tx_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |=> req_o);
    end else begin : g_rx_chk
      // R7
      rx_full_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == CNT_W'(DEPTH)) |=> req_o);
      // R7
      rx_empty_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |=> !req_o);
    end
  endgenerate

endmodule

// File: rtl/dual_wm_fifo.sv
module dual_wm_fifo
  import dwf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WM_W-1:0]  tx_wm_code,
  input  logic [WM_W-1:0]  rx_wm_code,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  input  logic             tx_flush,
  input  logic             tx_ovf_clr,
  input  logic             tx_udf_clr,
  output logic [CNT_W-1:0] tx_count,
  output logic             tx_ovf,
  output logic             tx_udf,
  output logic             tx_req,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  input  logic             rx_flush,
  input  logic             rx_ovf_clr,
  input  logic             rx_udf_clr,
  output logic [CNT_W-1:0] rx_count,
  output logic             rx_ovf,
  output logic             rx_udf,
  output logic             rx_req
);

  dwf_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_q (
    .clk, .rst_n,
    .push_i(tx_push), .wdata_i(tx_wdata), .pop_i(tx_pop), .rdata_o(tx_rdata),
    .flush_i(tx_flush), .ovf_clr_i(tx_ovf_clr), .udf_clr_i(tx_udf_clr),
    .cnt_o(tx_count), .ovf_o(tx_ovf), .udf_o(tx_udf)
  );

  dwf_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_q (
    .clk, .rst_n,
    .push_i(rx_push), .wdata_i(rx_wdata), .pop_i(rx_pop), .rdata_o(rx_rdata),
    .flush_i(rx_flush), .ovf_clr_i(rx_ovf_clr), .udf_clr_i(rx_udf_clr),
    .cnt_o(rx_count), .ovf_o(rx_ovf), .udf_o(rx_udf)
  );

  dwf_req_gen #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_req (
    .clk, .rst_n, .cnt_i(tx_count), .code_i(tx_wm_code), .req_o(tx_req)
  );

  dwf_req_gen #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_req (
    .clk, .rst_n, .cnt_i(rx_count), .code_i(rx_wm_code), .req_o(rx_req)
  );

  // R9
  tx_flush_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !rx_flush && !rx_push && !rx_pop) |=> $stable(rx_count));

  // R9
  rx_flush_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && !tx_flush && !tx_push && !tx_pop) |=> $stable(tx_count));

endmodule

// File: tb/dual_wm_fifo_tb.sv
`timescale 1ns/100ps
module dual_wm_fifo_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tx_wm_code = '0, rx_wm_code = '0;
  logic        tx_push = 0, tx_pop = 0, tx_flush = 0, tx_ovf_clr = 0, tx_udf_clr = 0;
  logic        rx_push = 0, rx_pop = 0, rx_flush = 0, rx_ovf_clr = 0, rx_udf_clr = 0;
  logic [31:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [4:0]  tx_count, rx_count;
  logic        tx_ovf, tx_udf, tx_req, rx_ovf, rx_udf, rx_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_wm_fifo u_dut (
    .clk, .rst_n, .tx_wm_code, .rx_wm_code,
    .tx_push, .tx_wdata, .tx_pop, .tx_rdata, .tx_flush, .tx_ovf_clr, .tx_udf_clr,
    .tx_count, .tx_ovf, .tx_udf, .tx_req,
    .rx_push, .rx_wdata, .rx_pop, .rx_rdata, .rx_flush, .rx_ovf_clr, .rx_udf_clr,
    .rx_count, .rx_ovf, .rx_udf, .rx_req
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_tx(input int code, input int n);
    int free;
    free = 16 - n;
    case (code)
      4: return free >= 12;
      5: return free >= 8;
      6: return free >= 4;
      7: return free >= 1;
      default: return free == 16;
    endcase
  endfunction

  function automatic logic exp_rx(input int code, input int n);
    case (code)
      4: return n >= 4;
      5: return n >= 8;
      6: return n >= 12;
      7: return n == 16;
      default: return n >= 1;
    endcase
  endfunction

  task automatic push_tx(input logic [31:0] d);
    tx_push = 1; tx_wdata = d; step(); tx_push = 0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    rx_push = 1; rx_wdata = d; step(); rx_push = 0;
  endtask

  task automatic pop_tx(output logic [31:0] d);
    d = tx_rdata; tx_pop = 1; step(); tx_pop = 0;
  endtask

  task automatic pop_rx(output logic [31:0] d);
    d = rx_rdata; rx_pop = 1; step(); rx_pop = 0;
  endtask

  task automatic flush_both();
    tx_flush = 1; rx_flush = 1; step(); tx_flush = 0; rx_flush = 0;
  endtask

  task automatic t_reset();
    repeat (3) step();
    check("R1 tx_count", tx_count, 0);
    check("R1 rx_count", rx_count, 0);
    check("R1 tx_req", tx_req, 0);
    check("R1 rx_req", rx_req, 0);
    check("R1 flags", {tx_ovf, tx_udf, rx_ovf, rx_udf}, 0);
    rst_n = 1;
    step();
  endtask

  task automatic t_order();
    logic [31:0] d;
    flush_both();
    for (int i = 0; i < 16; i++) begin
      push_tx(32'hA5000000 ^ (i * 32'h01010101));
      push_rx(32'h3C000000 + i * 7);
    end
    check("R3 tx full count", tx_count, 16);
    check("R3 rx full count", rx_count, 16);
    for (int i = 0; i < 16; i++) begin
      pop_tx(d); check("R2 tx order", d, 32'hA5000000 ^ (i * 32'h01010101));
      pop_rx(d); check("R2 rx order", d, 32'h3C000000 + i * 7);
    end
    check("R3 tx drained", tx_count, 0);
  endtask

  task automatic t_thresholds();
    flush_both();
    for (int n = 0; n <= 16; n++) begin
      for (int c = 0; c < 8; c++) begin
        tx_wm_code = 3'(c); rx_wm_code = 3'(c);
        step();
        check((c >= 1 && c <= 3) ? "R8 tx code" : "R6 tx req", tx_req, exp_tx(c, n));
        check((c >= 1 && c <= 3) ? "R8 rx code" : "R7 rx req", rx_req, exp_rx(c, n));
      end
      if (n < 16) begin
        tx_push = 1; rx_push = 1; step(); tx_push = 0; rx_push = 0;
      end
    end
  endtask

  task automatic t_req_latency();
    logic [31:0] d;
    flush_both();
    rx_wm_code = 3'b000;
    push_rx(32'h11);
    step();
    check("R7 rx req one entry", rx_req, 1);
    pop_rx(d);
    check("R7 rx req held one cycle", rx_req, 1);
    step();
    check("R7 rx req fell", rx_req, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    flush_both();
    for (int i = 0; i < 16; i++) push_tx(32'h100 + i);
    push_tx(32'hDEADBEEF);
    check("R4 count after full push", tx_count, 16);
    check("R4 ovf set", tx_ovf, 1);
    tx_push = 1; tx_wdata = 32'hBAD0BAD0; tx_pop = 1; step(); tx_push = 0; tx_pop = 0;
    check("R4 push with pop on full dropped", tx_count, 15);
    repeat (3) step();
    check("R4 ovf sticky", tx_ovf, 1);
    for (int i = 1; i < 16; i++) begin
      pop_tx(d); check("R4 data intact", d, 32'h100 + i);
    end
    check("R4 empty after drain", tx_count, 0);
    tx_ovf_clr = 1; step(); tx_ovf_clr = 0;
    check("R4 ovf cleared", tx_ovf, 0);
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    flush_both();
    pop_rx(d);
    check("R5 count stays 0", rx_count, 0);
    check("R5 udf set", rx_udf, 1);
    push_rx(32'h77);
    check("R5 udf sticky", rx_udf, 1);
    check("R5 next push counted", rx_count, 1);
    pop_rx(d);
    check("R5 data after udf", d, 32'h77);
    rx_udf_clr = 1; step(); rx_udf_clr = 0;
    check("R5 udf cleared", rx_udf, 0);
  endtask

  task automatic t_pair();
    logic [31:0] d;
    flush_both();
    push_tx(32'hA); push_tx(32'hB); push_tx(32'hC);
    d = tx_rdata;
    tx_push = 1; tx_wdata = 32'hD; tx_pop = 1; step(); tx_push = 0; tx_pop = 0;
    check("R3 pair count held", tx_count, 3);
    check("R3 pair popped head", d, 32'hA);
    pop_tx(d); check("R3 pair order B", d, 32'hB);
    pop_tx(d); check("R3 pair order C", d, 32'hC);
    pop_tx(d); check("R3 pair order D", d, 32'hD);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    flush_both();
    tx_ovf_clr = 1; step(); tx_ovf_clr = 0;
    for (int i = 0; i < 5; i++) push_tx(32'h500 + i);
    for (int i = 0; i < 3; i++) push_rx(32'h900 + i);
    pop_tx(d);
    tx_flush = 1; step(); tx_flush = 0;
    check("R9 tx emptied", tx_count, 0);
    check("R9 rx count kept", rx_count, 3);
    check("R9 flags kept", {tx_ovf, tx_udf}, 0);
    push_tx(32'hF0);
    pop_tx(d);
    check("R9 tx reusable", d, 32'hF0);
    pop_rx(d);
    check("R9 rx data kept", d, 32'h900);
    rx_flush = 1; step(); rx_flush = 0;
    check("R9 rx emptied", rx_count, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_thresholds();
    t_req_latency();
    t_overflow();
    t_underflow();
    t_pair();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule